// File: doc/BRIEF.md
# Three-Wire Serial Register Write Slave

This block accepts write commands on a three-wire serial bus: a serial clock, a data line and an active-high enable. It stores them in a 32-entry byte register file. Each enable-high window is one burst. The first full byte names the device, the second selects the starting register, and every further full byte is stored. After each stored byte the target address steps up by one, and it rolls over from 1Fh to 00h.

The bus lines are not used as a clock. They are resynchronised into a faster system clock, which must run at least 8 times the serial clock rate, and serial edges are found in that domain. A burst that is too short, or that carries a foreign device address, leaves the register file untouched. Bits that trail the last full byte are dropped.

The registers are read through a combinational parallel port. Each committed byte is also announced on a one-cycle write strobe, together with its address and value.

Top module: `serial_regfile_slave`

## Requirements
- R1: After reset every register reads 00h and the write strobe is low.
- R2: Data is taken on rising serial clock edges, most significant bit first, and eight consecutive bits form one byte.
- R3: The first data byte (the third byte of the burst) is stored at the address given by bits 4..0 of the second byte. Bits 7..5 of that byte are ignored.
- R4: A burst whose first byte differs from the DEV_ADDR parameter writes nothing.
- R5: Each further full byte in the same burst is stored at the previous address plus one.
- R6: After a byte is stored at address 1Fh, the next byte of the burst goes to address 00h.
- R7: A burst with 23 or fewer rising serial clock edges writes nothing.
- R8: Bits left after the last full byte of a burst change no register.
- R9: Bursts are accepted whether the serial clock rests low or high while the enable is low.
- R10: Serial clock edges and data while the enable is low have no effect.
- R11: Every stored byte raises wr_pulse for exactly one system cycle, with wr_addr and wr_data showing the address and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sen_i | input | 1 | Serial enable, active high, asynchronous |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register contents at rd_addr |
| wr_pulse | output | 1 | One-cycle strobe for each stored byte |
| wr_addr | output | 5 | Address of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
The hardest case to reach is the address rollover inside a single burst. To get there, one enable window must carry the device byte, a start address near the top of the map and several data bytes. The bench starts at 1Dh and sends four data bytes, which crosses 1Fh into 00h.

Bursts are also sent with the serial clock resting high. In that case the first clock transition after the enable rises is a falling edge, and the framer must not count it as a bit.

// File: rtl/srw_pkg.sv
package srw_pkg;
    localparam int unsigned SRW_BYTE_W = 8;
    localparam int unsigned SRW_ADDR_W = 5;
    localparam int unsigned SRW_BIT_CW = $clog2(SRW_BYTE_W);

    typedef logic [SRW_BYTE_W-1:0] byte_t;
    typedef logic [SRW_ADDR_W-1:0] raddr_t;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic en;
    } line_t;

    typedef struct packed {
        logic   valid;
        raddr_t addr;
        byte_t  data;
    } wr_cmd_t;

    function automatic raddr_t next_addr(input raddr_t a);
        return raddr_t'(a + 1'b1);
    endfunction
endpackage

// File: rtl/srw_sync.sv
module srw_sync
    import srw_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t raw,
    output line_t synced,
    output logic  sclk_rise,
    output logic  en_rise
);
    line_t chain [STAGES];
    line_t prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[STAGES-1];
    end

    assign synced    = chain[STAGES-1];
    assign sclk_rise = synced.sclk & ~prev.sclk;
    assign en_rise   = synced.en & ~prev.en;
endmodule

// File: rtl/srw_framer.sv
module srw_framer
    import srw_pkg::*;
#(
    parameter byte_t DEV_ADDR = 8'h5A
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en_lvl,
    input  logic    en_rise,
    input  logic    sclk_rise,
    input  logic    sdata,
    output wr_cmd_t wr
);
    phase_e                phase;
    logic [SRW_BIT_CW-1:0] bit_cnt;
    byte_t                 shreg;
    raddr_t                addr;
    byte_t                 byte_in;
    logic                  byte_done;

    assign byte_in   = {shreg[SRW_BYTE_W-2:0], sdata};
    assign byte_done = (bit_cnt == SRW_BIT_CW'(SRW_BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_DEV;
            bit_cnt <= '0;
            shreg   <= '0;
            addr    <= '0;
            wr      <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (en_rise) begin
                // a new window always starts from the device byte
                phase   <= PH_DEV;
                bit_cnt <= '0;
            end else if (en_lvl && sclk_rise) begin
                shreg   <= byte_in;
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    unique case (phase)
                        PH_DEV:  phase <= (byte_in == DEV_ADDR) ? PH_REG : PH_DROP;
                        PH_REG: begin
                            addr  <= byte_in[SRW_ADDR_W-1:0];
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            wr.valid <= 1'b1;
                            wr.addr  <= addr;
                            wr.data  <= byte_in;
                            addr     <= next_addr(addr);
                        end
                        PH_DROP: phase <= PH_DROP;
                        default: phase <= PH_DROP;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/srw_regbank.sv
module srw_regbank
    import srw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t wr,
    input  raddr_t  rd_addr,
    output byte_t   rd_data
);
    localparam int unsigned DEPTH = 1 << SRW_ADDR_W;

    byte_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr.valid && wr.addr == raddr_t'(i))
                mem[i] <= wr.data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_regfile_slave.sv
module serial_regfile_slave
    import srw_pkg::*;
#(
    parameter byte_t       DEV_ADDR    = 8'h5A,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_i,
    input  logic                  sdata_i,
    input  logic                  sen_i,
    input  logic [SRW_ADDR_W-1:0] rd_addr,
    output logic [SRW_BYTE_W-1:0] rd_data,
    output logic                  wr_pulse,
    output logic [SRW_ADDR_W-1:0] wr_addr,
    output logic [SRW_BYTE_W-1:0] wr_data
);
    line_t   raw;
    line_t   synced;
    logic    sclk_rise;
    logic    en_rise;
    logic    en_lvl;
    wr_cmd_t wr;

    assign raw    = '{sclk: sclk_i, sdata: sdata_i, en: sen_i};
    assign en_lvl = synced.en;

    srw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .raw       (raw),
        .synced    (synced),
        .sclk_rise (sclk_rise),
        .en_rise   (en_rise)
    );

    srw_framer #(.DEV_ADDR(DEV_ADDR)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .en_lvl    (en_lvl),
        .en_rise   (en_rise),
        .sclk_rise (sclk_rise),
        .sdata     (synced.sdata),
        .wr        (wr)
    );

    srw_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign wr_pulse = wr.valid;
    assign wr_addr  = wr.addr;
    assign wr_data  = wr.data;
endmodule

// File: rtl/srw_checker.sv
module srw_checker
    import srw_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   en_lvl,
    input logic   en_rise,
    input logic   sclk_rise,
    input logic   wr_pulse,
    input raddr_t wr_addr
);
    logic [7:0] edge_cnt;
    logic       seen;
    raddr_t     last;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt <= '0;
            seen     <= 1'b0;
            last     <= '0;
        end else begin
            if (en_rise)
                edge_cnt <= '0;
            else if (en_lvl && sclk_rise && edge_cnt != 8'hFF)
                edge_cnt <= edge_cnt + 1'b1;
            if (en_rise)
                seen <= 1'b0;
            else if (wr_pulse) begin
                seen <= 1'b1;
                last <= wr_addr;
            end
        end
    end

    assert_only_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(en_lvl && sclk_rise));

    assert_min_edges_R7: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> edge_cnt >= 8'd24);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && seen && !en_rise) |-> wr_addr == raddr_t'(last + 1'b1));

    assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
endmodule

bind serial_regfile_slave srw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_lvl    (en_lvl),
    .en_rise   (en_rise),
    .sclk_rise (sclk_rise),
    .wr_pulse  (wr_pulse),
    .wr_addr   (wr_addr)
);

// File: tb/serial_regfile_slave_test.sv
module serial_regfile_slave_test;
    localparam time        CLK_PERIOD = 10ns;
    localparam time        HALF_SCLK  = 100ns;
    localparam logic [7:0] DEV        = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_i = 1'b0;
    logic       sdata_i = 1'b0;
    logic       sen_i = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_pulse;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int exp_pulses = 0;
    bit finished = 1'b0;
    logic [7:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_regfile_slave #(.DEV_ADDR(DEV)) uut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i), .sen_i(sen_i),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) if (!rst && wr_pulse) pulses <= pulses + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            rd_addr = 5'(a);
            #1;
            check(req, {24'h0, rd_data}, {24'h0, model[a]});
        end
        check({req, " strobe count"}, pulses, exp_pulses);
    endtask

    // bits are taken from stream[63] downward
    task automatic send(input logic [63:0] stream, input int nbits, input bit idle_high);
        logic [4:0] a;
        sclk_i = idle_high;
        #(HALF_SCLK);
        sen_i = 1'b1;
        #(HALF_SCLK);
        for (int i = 0; i < nbits; i++) begin
            sclk_i  = 1'b0;
            sdata_i = stream[63-i];
            #(HALF_SCLK);
            sclk_i = 1'b1;
            #(HALF_SCLK);
        end
        sclk_i = idle_high;
        #(HALF_SCLK);
        sen_i = 1'b0;
        #(HALF_SCLK);
        repeat (10) @(posedge clk);
        if (nbits >= 24 && stream[63:56] == DEV) begin
            a = stream[52:48];
            for (int k = 2; k < nbits / 8; k++) begin
                model[a] = stream[63-8*k -: 8];
                a = a + 5'd1;
                exp_pulses++;
            end
        end
    endtask

    task automatic t_reset();
        for (int a = 0; a < 32; a++) model[a] = 8'h00;
        check("R1 strobe", {31'h0, wr_pulse}, 32'h0);
        check_all("R1");
    endtask

    task automatic t_single();
        send({DEV, 8'h03, 8'hA5, 40'h0}, 24, 1'b0);
        send({DEV, 8'h04, 8'h81, 40'h0}, 24, 1'b0);
        check_all("R2 R3");
    endtask

    task automatic t_upper_bits_and_idle_high();
        send({DEV, 8'hE7, 8'h18, 40'h0}, 24, 1'b1);
        check_all("R3 R9");
    endtask

    task automatic t_wrap();
        send({DEV, 8'h1D, 8'h11, 8'h22, 8'h33, 8'h44, 16'h0}, 48, 1'b0);
        check_all("R5 R6 R11");
    endtask

    task automatic t_short();
        send({DEV, 8'h08, 8'hFF, 40'h0}, 23, 1'b0);
        check_all("R7");
    endtask

    task automatic t_foreign();
        send({8'h5B, 8'h09, 8'h77, 40'h0}, 24, 1'b0);
        check_all("R4");
    endtask

    task automatic t_partial();
        send({DEV, 8'h0A, 8'h3C, 8'hF0, 32'h0}, 29, 1'b1);
        check_all("R8");
    endtask

    task automatic t_enable_low();
        for (int i = 0; i < 40; i++) begin
            sdata_i = i[0];
            sclk_i  = ~sclk_i;
            #(HALF_SCLK);
        end
        sclk_i = 1'b0;
        repeat (10) @(posedge clk);
        check_all("R10");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (4) @(posedge clk);
        t_reset();
        t_single();
        t_upper_bits_and_idle_high();
        t_wrap();
        t_short();
        t_foreign();
        t_partial();
        t_enable_low();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule